// File: doc/BRIEF.md
# Reconfigurable Cyclic Prefix Inserter

This block takes the sample stream produced by an inverse FFT engine and turns every packet into a complete multicarrier symbol. The symbol is a guard interval followed by the whole packet, and the guard interval is a copy of the packet's own tail. Each packet brings its own size code and guard length on its first beat. Both values can therefore change from one packet to the next while the block is running, and the guard length can be any integer up to the field's range.

The block writes the incoming packet into one of two internal sample banks. Once the packet is complete, it reads that bank back starting at address `len - cp`, wraps to address 0 after the last sample, and stops after `len + cp` reads. While one bank is being read, the next packet fills the other bank. The input therefore stalls only when both banks hold packets that have not yet been read out. The output is a valid/ready stream that carries start and end markers for each symbol.

Top module: `cp_inserter`

## Requirements
- R1: Each output symbol consists of the last `cp` samples of its packet, in packet order, followed by all of the packet's samples in order. The symbol is `len + cp` beats long, where `len` is the packet length.
- R2: `in_size_code` selects the nominal packet length `N`. Code 0 is 128 and each further code doubles it: 1 is 256, 2 is 512, 3 is 1024 and 4 is 2048. Codes 5 to 7 are treated as 2048.
- R3: The size code and guard length are captured on the input beat that has `in_sop` set. They apply to that packet only, so consecutive packets may use different values.
- R4: With a guard length of 0, the packet passes through unchanged and produces `len` output beats.
- R5: A guard length larger than the packet length is limited to the packet length, so the whole packet appears twice.
- R6: A packet closes on the beat with `in_eop` set or on its `N`-th beat, whichever comes first. The closing beat sets `len`.
- R7: While no packet is open, the block accepts input beats without `in_sop` and discards them. They produce no output.
- R8: `out_sop` is high only on the first beat of a symbol and `out_eop` only on its last beat.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values.
- R10: The block accepts a second packet while the first is still waiting for output. `in_ready` goes low only when two complete packets are held that have not yet been fully read out.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | DATA_W | Input sample |
| in_size_code | input | SIZE_W | Packet size code, sampled with `in_sop` |
| in_cp_len | input | CP_W | Guard length in samples, sampled with `in_sop` |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sop | output | 1 | First beat of a symbol |
| out_eop | output | 1 | Last beat of a symbol |
| out_data | output | DATA_W | Output sample |

## Verification
The bound assertions check the following on every cycle. Output beats hold steady while the output is stalled. Start and end markers alternate correctly, with no beat outside a symbol. A symbol never starts without a completed input packet behind it. The input stalls only when two packets are held, and the port state right after reset is as required. The content of each symbol can only be shown by the bench scenarios, which compare every output beat against an independently computed sequence. That content includes the tail-then-body order, the size decoding, per-packet reconfiguration, guard clamping, early end-of-packet and the discarding of orphan beats.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

  typedef enum logic [0:0] {RD_IDLE, RD_RUN} rd_state_e;

  // Nominal packet length for a size code, saturated at the largest size.
  function automatic int unsigned code_to_len(input int unsigned code,
                                              input int unsigned min_log2,
                                              input int unsigned max_log2);
    int unsigned e;
    e = min_log2 + code;
    if (e > max_log2) e = max_log2;
    return 32'd1 << e;
  endfunction

endpackage

// File: rtl/cpi_sample_ram.sv
module cpi_sample_ram #(
  parameter int DATA_W = 16,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [0:DEPTH-1];

  // Simple dual-port RAM with a registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cpi_writer.sv
module cpi_writer #(
  parameter  int SIZE_W   = 3,
  parameter  int CP_W     = 11,
  parameter  int MIN_LOG2 = 7,
  parameter  int MAX_LOG2 = 11,
  localparam int ADDR_W   = MAX_LOG2,
  localparam int LEN_W    = MAX_LOG2 + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_sop,
  input  logic                       in_eop,
  input  logic [SIZE_W-1:0]          in_size_code,
  input  logic [CP_W-1:0]            in_cp_len,
  output logic                       we,
  output logic [ADDR_W:0]            waddr,
  input  logic                       rel_valid,
  input  logic                       rel_bank,
  output logic [1:0]                 bank_full,
  output logic [1:0][LEN_W-1:0]      cfg_len,
  output logic [1:0][CP_W-1:0]       cfg_cp
);

  logic              wr_bank;
  logic [ADDR_W-1:0] wr_addr;
  logic              pkt_open;
  logic [LEN_W-1:0]  cur_n;

  logic              accept;
  logic              start;
  logic              take;
  logic              last;
  logic [ADDR_W-1:0] a;
  logic [LEN_W-1:0]  n_pkt;
  logic [LEN_W-1:0]  done_len;

  assign in_ready = !bank_full[wr_bank];

  always_comb begin
    accept   = in_valid && in_ready;
    start    = accept && in_sop;
    take     = start || (accept && pkt_open);
    a        = start ? '0 : wr_addr;
    n_pkt    = start ? LEN_W'(cpi_pkg::code_to_len(int'(in_size_code), MIN_LOG2, MAX_LOG2))
                     : cur_n;
    last     = take && (in_eop || ({1'b0, a} == n_pkt - 1'b1));
    done_len = {1'b0, a} + 1'b1;
    we       = take;
    waddr    = {wr_bank, a};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bank  <= 1'b0;
      wr_addr  <= '0;
      pkt_open <= 1'b0;
      cur_n    <= '0;
    end else if (take) begin
      if (start) cur_n <= n_pkt;
      if (last) begin
        pkt_open <= 1'b0;
        wr_bank  <= ~wr_bank;
        wr_addr  <= '0;
      end else begin
        pkt_open <= 1'b1;
        wr_addr  <= a + 1'b1;
      end
    end
  end

  // Per-bank occupancy and captured packet settings.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_full[b] <= 1'b0;
        cfg_len[b]   <= '0;
        cfg_cp[b]    <= '0;
      end else begin
        if (last && wr_bank == 1'(b)) begin
          bank_full[b] <= 1'b1;
          cfg_len[b]   <= done_len;
        end else if (rel_valid && rel_bank == 1'(b)) begin
          bank_full[b] <= 1'b0;
        end
        if (start && wr_bank == 1'(b)) cfg_cp[b] <= in_cp_len;
      end
    end
  end

endmodule

// File: rtl/cpi_reader.sv
module cpi_reader #(
  parameter  int DATA_W   = 16,
  parameter  int CP_W     = 11,
  parameter  int MAX_LOG2 = 11,
  localparam int ADDR_W   = MAX_LOG2,
  localparam int LEN_W    = MAX_LOG2 + 1,
  localparam int CNT_W    = MAX_LOG2 + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            bank_full,
  input  logic [1:0][LEN_W-1:0] cfg_len,
  input  logic [1:0][CP_W-1:0]  cfg_cp,
  output logic [ADDR_W:0]       raddr,
  input  logic [DATA_W-1:0]     rdata,
  output logic                  rel_valid,
  output logic                  rel_bank,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [DATA_W-1:0]     out_data
);

  cpi_pkg::rd_state_e state;
  logic              rd_bank;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  len_r;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  total;

  logic [CNT_W-1:0]  len_sel;
  logic [CNT_W-1:0]  cp_sel;
  logic [CNT_W-1:0]  l_eff;

  logic              pend;
  logic              pend_sop;
  logic              pend_eop;

  logic [DATA_W+1:0] fq [2];
  logic              wp;
  logic              rp;
  logic [1:0]        fcnt;

  logic              pop;
  logic              issue;
  logic              last_rd;

  always_comb begin
    len_sel   = CNT_W'(cfg_len[rd_bank]);
    cp_sel    = CNT_W'(cfg_cp[rd_bank]);
    l_eff     = (cp_sel > len_sel) ? len_sel : cp_sel;
    pop       = (fcnt != 2'd0) && out_ready;
    issue     = (state == cpi_pkg::RD_RUN) &&
                (({1'b0, fcnt} + {2'b0, pend}) < (3'd2 + {2'b0, pop}));
    last_rd   = (cnt == total - 1'b1);
    rel_valid = issue && last_rd;
    rel_bank  = rd_bank;
    raddr     = {rd_bank, addr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= cpi_pkg::RD_IDLE;
      rd_bank  <= 1'b0;
      addr     <= '0;
      len_r    <= '0;
      cnt      <= '0;
      total    <= '0;
      pend     <= 1'b0;
      pend_sop <= 1'b0;
      pend_eop <= 1'b0;
    end else begin
      pend     <= issue;
      pend_sop <= issue && (cnt == '0);
      pend_eop <= issue && last_rd;
      case (state)
        cpi_pkg::RD_IDLE: begin
          if (bank_full[rd_bank]) begin
            state <= cpi_pkg::RD_RUN;
            len_r <= len_sel;
            total <= len_sel + l_eff;
            cnt   <= '0;
            addr  <= (l_eff == '0) ? '0 : ADDR_W'(len_sel - l_eff);
          end
        end
        default: begin
          if (issue) begin
            cnt  <= cnt + 1'b1;
            addr <= (CNT_W'(addr) == len_r - 1'b1) ? '0 : addr + 1'b1;
            if (last_rd) begin
              state   <= cpi_pkg::RD_IDLE;
              rd_bank <= ~rd_bank;
            end
          end
        end
      endcase
    end
  end

  // Two-entry output queue absorbing the RAM read latency.
  always_ff @(posedge clk) begin
    if (pend) fq[wp] <= {pend_sop, pend_eop, rdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= 1'b0;
      rp   <= 1'b0;
      fcnt <= 2'd0;
    end else begin
      if (pend) wp <= ~wp;
      if (pop)  rp <= ~rp;
      case ({pend, pop})
        2'b10:   fcnt <= fcnt + 1'b1;
        2'b01:   fcnt <= fcnt - 1'b1;
        default: fcnt <= fcnt;
      endcase
    end
  end

  assign out_valid = (fcnt != 2'd0);
  assign out_sop   = fq[rp][DATA_W+1];
  assign out_eop   = fq[rp][DATA_W];
  assign out_data  = fq[rp][DATA_W-1:0];

endmodule

// File: rtl/cp_inserter.sv
module cp_inserter #(
  parameter int DATA_W   = 16,
  parameter int SIZE_W   = 3,
  parameter int CP_W     = 11,
  parameter int MIN_LOG2 = 7,
  parameter int MAX_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SIZE_W-1:0] in_size_code,
  input  logic [CP_W-1:0]   in_cp_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data
);

  localparam int ADDR_W = MAX_LOG2;
  localparam int LEN_W  = MAX_LOG2 + 1;
  localparam int RAM_AW = ADDR_W + 1;

  logic                  we;
  logic [ADDR_W:0]       waddr;
  logic [ADDR_W:0]       raddr;
  logic [DATA_W-1:0]     rdata;
  logic                  rel_valid;
  logic                  rel_bank;
  logic [1:0]            bank_full;
  logic [1:0][LEN_W-1:0] cfg_len;
  logic [1:0][CP_W-1:0]  cfg_cp;

  cpi_writer #(
    .SIZE_W(SIZE_W), .CP_W(CP_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)
  ) u_writer (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .in_size_code(in_size_code), .in_cp_len(in_cp_len),
    .we(we), .waddr(waddr),
    .rel_valid(rel_valid), .rel_bank(rel_bank),
    .bank_full(bank_full), .cfg_len(cfg_len), .cfg_cp(cfg_cp)
  );

  cpi_sample_ram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(in_data),
    .raddr(raddr), .rdata(rdata)
  );

  cpi_reader #(.DATA_W(DATA_W), .CP_W(CP_W), .MAX_LOG2(MAX_LOG2)) u_reader (
    .clk(clk), .rst(rst),
    .bank_full(bank_full), .cfg_len(cfg_len), .cfg_cp(cfg_cp),
    .raddr(raddr), .rdata(rdata),
    .rel_valid(rel_valid), .rel_bank(rel_bank),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

endmodule

// File: rtl/cpi_checker.sv
module cpi_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_eop,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sop,
  input logic              out_eop,
  input logic [DATA_W-1:0] out_data
);

  logic [15:0] pkts_in;
  logic [15:0] sym_start;
  logic [15:0] sym_done;
  logic        in_sym;
  logic        rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      pkts_in   <= '0;
      sym_start <= '0;
      sym_done  <= '0;
      in_sym    <= 1'b0;
    end else begin
      if (in_valid && in_ready && in_eop) pkts_in <= pkts_in + 1'b1;
      if (out_valid && out_ready) begin
        if (out_sop) sym_start <= sym_start + 1'b1;
        if (out_eop) sym_done  <= sym_done + 1'b1;
        if (out_eop)      in_sym <= 1'b0;
        else if (out_sop) in_sym <= 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_q && !rst) begin
      AST_RESET_STATE: assert (!out_valid && in_ready); // R11
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)); // R9

  AST_SOP_OPENS_SYMBOL: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sop |-> !in_sym); // R8

  AST_BODY_INSIDE_SYMBOL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_sop |-> in_sym); // R8

  AST_NO_PHANTOM_SYMBOL: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sop |-> pkts_in != sym_start); // R1

  AST_STALL_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (pkts_in - sym_done) >= 16'd2); // R10

endmodule

bind cp_inserter cpi_checker #(.DATA_W(DATA_W)) u_cpi_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_eop(in_eop),
  .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
  .out_eop(out_eop), .out_data(out_data)
);

// File: tb/cp_inserter_bench.sv
module cp_inserter_bench;

  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              in_sop = 1'b0;
  logic              in_eop = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [2:0]        in_size_code = '0;
  logic [10:0]       in_cp_len = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic              out_sop;
  logic              out_eop;
  logic [DATA_W-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  int ready_mode = 0;   // 0 always ready, 1 random, 2 held low

  logic [DATA_W+1:0] exp_q[$];
  string             tag_q[$];

  logic              hold_seen = 1'b0;
  logic [DATA_W+1:0] held;

  always #5 clk = ~clk;

  cp_inserter u_cp_inserter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .in_size_code(in_size_code), .in_cp_len(in_cp_len),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Output side: choose ready, then score the beat that the next edge transfers.
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_seen)
        check(out_valid && {out_sop, out_eop, out_data} == held, "R9", "stalled beat changed",
              int'({out_valid, out_sop, out_eop, out_data}), int'({1'b1, held}));
      case (ready_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = 1'($urandom_range(0, 1));
        default: out_ready = 1'b0;
      endcase
      hold_seen = out_valid && !out_ready;
      held      = {out_sop, out_eop, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected output beat", int'({out_sop, out_eop, out_data}), 0);
        end else begin
          logic [DATA_W+1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_sop, out_eop, out_data} == e, t, "output beat {sop,eop,data}",
                int'({out_sop, out_eop, out_data}), int'(e));
        end
      end
    end
  end

  // Build the expected symbol, then drive the packet (R1, R2, R6).
  task automatic send_packet(input int code, input int cp, input int beats,
                             input int base, input string tag);
    int n, len, leff, tot, k;
    n    = 128 << ((code > 4) ? 4 : code);
    len  = (beats < n) ? beats : n;
    leff = (cp < len) ? cp : len;
    tot  = len + leff;
    k    = 0;
    for (int i = len - leff; i < len; i++) begin
      exp_q.push_back({k == 0, k == tot - 1, DATA_W'(base + i)});
      tag_q.push_back(tag);
      k++;
    end
    for (int i = 0; i < len; i++) begin
      exp_q.push_back({k == 0, k == tot - 1, DATA_W'(base + i)});
      tag_q.push_back(tag);
      k++;
    end
    for (int i = 0; i < beats; i++) begin
      in_valid     = 1'b1;
      in_sop       = (i == 0);
      in_eop       = (i == beats - 1);
      in_data      = DATA_W'(base + i);
      in_size_code = (i == 0) ? 3'(code) : 3'(7 - code);   // junk outside sop (R3)
      in_cp_len    = (i == 0) ? 11'(cp) : 11'h7FF;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic drain(input string tag);
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, tag, "symbol beats still missing", exp_q.size(), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R11", "in_ready after reset", int'(in_ready), 1);
    @(negedge clk);
  endtask

  task automatic t_basic();
    ready_mode = 0;
    send_packet(0, 16, 128, 16'h1000, "R1");
    drain("R8");
  endtask

  task automatic t_zero_cp();
    ready_mode = 1;
    send_packet(0, 0, 128, 16'h2000, "R4");
    drain("R4");
  endtask

  task automatic t_reconfig();
    ready_mode = 1;
    send_packet(1, 37, 256, 16'h3000, "R3");
    send_packet(2, 100, 512, 16'h4000, "R3");
    send_packet(3, 1, 1024, 16'h5000, "R2");
    drain("R3");
    send_packet(4, 2047, 2048, 16'h6000, "R2");
    send_packet(7, 5, 2048, 16'h7000, "R2");
    drain("R2");
  endtask

  task automatic t_clamp();
    ready_mode = 1;
    send_packet(0, 300, 128, 16'h8000, "R5");
    drain("R5");
  endtask

  task automatic t_early_eop();
    ready_mode = 1;
    send_packet(1, 10, 50, 16'h9000, "R6");
    send_packet(0, 3, 1, 16'h9100, "R6");
    drain("R6");
  endtask

  task automatic t_orphans();
    ready_mode = 0;
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1;
      in_sop   = 1'b0;
      in_eop   = 1'b0;
      in_data  = 16'hDEAD;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(out_valid == 1'b0, "R7", "output from discarded beats", int'(out_valid), 0);
    send_packet(0, 4, 128, 16'hA000, "R7");
    drain("R7");
  endtask

  task automatic t_pingpong();
    ready_mode = 2;
    send_packet(0, 8, 128, 16'hB000, "R10");
    repeat (5) @(negedge clk);
    check(in_ready == 1'b1, "R10", "in_ready with one packet held", int'(in_ready), 1);
    send_packet(0, 8, 128, 16'hC000, "R10");
    repeat (20) @(negedge clk);
    check(in_ready == 1'b0, "R10", "in_ready with two packets held", int'(in_ready), 0);
    check(out_valid == 1'b1, "R9", "out_valid while stalled", int'(out_valid), 1);
    ready_mode = 1;
    drain("R10");
    check(in_ready == 1'b1, "R10", "in_ready after drain", int'(in_ready), 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_zero_cp();
    t_reconfig();
    t_clamp();
    t_early_eop();
    t_orphans();
    t_pingpong();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog expired: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule